// File: doc/BRIEF.md
# Macro Engine ALU with Persistent Carry

This block is the arithmetic and logic unit of a small command-processing macro engine. Each cycle it combines two data words under a five-bit operation code and returns a result word. Four arithmetic operations form a carry chain: plain add and subtract, plus add-with-carry and subtract-with-borrow, which consume a one-bit carry flag held inside the block. Five bitwise operations (xor, or, and, and-not, nand) leave that flag alone. Any other operation code is flagged as illegal and produces zero.

The result and the illegal flag are combinational. The carry flag is a register that is written only on a clock edge where the enable strobe is high. The surrounding engine chooses the operands and writes the result back. A multi-word add or subtract is built from one plain operation followed by carry-chained operations.

Top module: `macro_alu`

## Requirements
- R1: Code 0 (add) gives `result = a + b` modulo 2^32. On an enabled edge the carry flag takes the carry out of bit 31.
- R2: Code 1 (add with carry) gives `result = a + b + carry` modulo 2^32. On an enabled edge the carry flag takes the carry out of bit 31 of that sum.
- R3: Code 2 (subtract) gives `result = a - b` modulo 2^32. On an enabled edge the carry flag becomes 1 when no borrow occurs (`a >= b`) and 0 otherwise.
- R4: Code 3 (subtract with borrow) gives `result = a - b - (1 - carry)` modulo 2^32. On an enabled edge the carry flag becomes 1 exactly when `a >= b + (1 - carry)`.
- R5: Codes 8 to 12 give, in order, `a ^ b`, `a | b`, `a & b`, `a & ~b` and `~(a & b)`. These codes leave the carry flag unchanged.
- R6: Codes 4 to 7 and codes 13 to 31 drive `result` to 0 and `illegal` to 1, and leave the carry flag unchanged. The codes 0 to 3 and 8 to 12 hold `illegal` at 0.
- R7: The carry flag changes only on a rising clock edge where `en` is 1. With `en` at 0 it holds its value whatever the code and operands are.
- R8: An active-low reset clears the carry flag to 0.
- R9: `result` and `illegal` follow the inputs and the current carry flag in the same cycle. A carry update becomes visible at `carry` after the rising edge that samples `en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable: commits the carry update on this edge |
| op | input | 5 | Operation code |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| result | output | 32 | Combinational result |
| carry | output | 1 | Registered carry flag |
| illegal | output | 1 | Operation code is not a valid operation |

## Verification
`result` and `illegal` are due in the same cycle as their inputs. The bench samples them one nanosecond after the falling edge on which it drives the inputs, which is well before the next rising edge can move the carry flag they depend on. The carry update is due one rising edge later, so the monitor checks `carry` one nanosecond after that edge, against a model carry that the driver advances only for enabled arithmetic codes. Each queued item carries both expectations, so the timing of every check is tied to the stimulus that produced it.

// File: rtl/macro_alu.sv
module macro_alu #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [4:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] result,
  output logic          carry,
  output logic          illegal
);

  localparam logic [4:0] OP_ADD  = 5'd0;
  localparam logic [4:0] OP_ADC  = 5'd1;
  localparam logic [4:0] OP_SUB  = 5'd2;
  localparam logic [4:0] OP_SBB  = 5'd3;
  localparam logic [4:0] OP_XOR  = 5'd8;
  localparam logic [4:0] OP_OR   = 5'd9;
  localparam logic [4:0] OP_AND  = 5'd10;
  localparam logic [4:0] OP_ANDN = 5'd11;
  localparam logic [4:0] OP_NAND = 5'd12;

  logic          arith;
  logic          inv_b;
  logic          cin;
  logic [DW-1:0] b_eff;
  logic [DW:0]   sum;

  // Codes 0..3 share one adder: bit 1 inverts b, bit 0 feeds the stored carry.
  assign arith = (op[4:2] == 3'b000);
  assign inv_b = op[1];
  assign b_eff = inv_b ? ~b : b;
  assign cin   = op[0] ? carry : inv_b;
  assign sum   = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};

  always_comb begin
    illegal = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: result = sum[DW-1:0];
      OP_XOR:  result = a ^ b;
      OP_OR:   result = a | b;
      OP_AND:  result = a & b;
      OP_ANDN: result = a & ~b;
      OP_NAND: result = ~(a & b);
      default: begin
        result  = '0;
        illegal = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          carry <= 1'b0;
    else if (en && arith) carry <= sum[DW];
  end

endmodule

// File: rtl/macro_alu_chk.sv
module macro_alu_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [4:0]    op,
  input logic [DW-1:0] a,
  input logic [DW-1:0] b,
  input logic [DW-1:0] result,
  input logic          carry,
  input logic          illegal
);

  a_r6_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (result == '0));

  a_r6_illegal_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (en && illegal) |=> $stable(carry));

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(carry));

  a_r5_logic_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op >= 5'd8 && op <= 5'd12) |=> $stable(carry));

  a_r1_add_carry_out: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 5'd0) |=> (carry == (({1'b0, $past(a)} + {1'b0, $past(b)}) >> DW)));

  a_r3_sub_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 5'd2) |=> (carry == ($past(a) >= $past(b))));

endmodule

bind macro_alu macro_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .op(op), .a(a), .b(b),
  .result(result), .carry(carry), .illegal(illegal)
);

// File: tb/test_macro_alu.sv
`timescale 1ns/1ps
module test_macro_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [4:0]  op = '0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [31:0] result;
  logic        carry;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit model_c = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        ill;
    logic        c_after;
    string       req;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  macro_alu i_macro_alu (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .a(a), .b(b),
    .result(result), .carry(carry), .illegal(illegal)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                       input bit e, input string req);
    item_t it;
    logic [32:0] bor;
    @(negedge clk);
    op = o; a = x; b = y; en = e;
    it.ill = 1'b0;
    it.c_after = model_c;
    it.req = req;
    case (o)
      5'd0: begin it.res = x + y; if (e) model_c = ({1'b0, x} + {1'b0, y}) > 33'hFFFF_FFFF; end
      5'd1: begin it.res = x + y + model_c;
                  if (e) model_c = ({1'b0, x} + {1'b0, y} + model_c) > 33'hFFFF_FFFF; end
      5'd2: begin it.res = x - y; if (e) model_c = (x >= y); end
      5'd3: begin bor = {1'b0, y} + (model_c ? 33'd0 : 33'd1);
                  it.res = x - bor[31:0]; if (e) model_c = ({1'b0, x} >= bor); end
      5'd8:  it.res = x ^ y;
      5'd9:  it.res = x | y;
      5'd10: it.res = x & y;
      5'd11: it.res = x & ~y;
      5'd12: it.res = ~(x & y);
      default: begin it.res = '0; it.ill = 1'b1; end
    endcase
    it.c_after = model_c;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk); #1;
      if (q.size() != 0) begin
        it = q[0];
        check(result === it.res, it.req, "result", result, it.res);
        check(illegal === it.ill, it.req, "illegal", {31'b0, illegal}, {31'b0, it.ill});
        @(posedge clk); #1;
        check(carry === it.c_after, it.req, "carry", {31'b0, carry}, {31'b0, it.c_after});
        void'(q.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    // R8: reset clears the carry flag
    repeat (2) @(posedge clk);
    #1 check(carry === 1'b0, "R8", "carry in reset", {31'b0, carry}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check(carry === 1'b0, "R8", "carry after reset", {31'b0, carry}, 32'd0);

    drive(5'd0, 32'hFFFF_FFFF, 32'd1, 1, "R1");        // wraps, carry 1
    drive(5'd1, 32'd1, 32'd1, 1, "R2");                // 1+1+1
    drive(5'd0, 32'd7, 32'd9, 1, "R1");                // carry 0
    drive(5'd1, 32'hFFFF_FFFF, 32'd0, 1, "R2");        // no carry in
    drive(5'd0, 32'h8000_0000, 32'h8000_0000, 1, "R1");
    drive(5'd1, 32'hFFFF_FFFF, 32'd0, 1, "R2");        // carry in 1 wraps
    drive(5'd2, 32'd5, 32'd3, 1, "R3");
    drive(5'd2, 32'd3, 32'd5, 1, "R3");                // borrow
    drive(5'd2, 32'd4, 32'd4, 1, "R3");                // equal: no borrow
    drive(5'd2, 32'd0, 32'd1, 1, "R3");                // carry -> 0
    drive(5'd3, 32'd10, 32'd3, 1, "R4");               // borrow in
    drive(5'd3, 32'd0, 32'd0, 1, "R4");                // carry 1 in
    drive(5'd2, 32'd0, 32'd1, 1, "R3");
    drive(5'd3, 32'd0, 32'd0, 1, "R4");                // 0-0-1
    drive(5'd3, 32'd1, 32'd0, 1, "R4");
    // R5 logic codes; set carry to 1 first so "unchanged" is visible
    drive(5'd0, 32'hFFFF_FFFF, 32'd1, 1, "R1");
    drive(5'd8,  32'hF0F0_1234, 32'h0FF0_FFFF, 1, "R5");
    drive(5'd9,  32'hF0F0_1234, 32'h0FF0_0000, 1, "R5");
    drive(5'd10, 32'hF0F0_1234, 32'h0FF0_FFFF, 1, "R5");
    drive(5'd11, 32'hF0F0_1234, 32'h0FF0_00FF, 1, "R5");
    drive(5'd12, 32'hF0F0_1234, 32'h0FF0_00FF, 1, "R5");
    // R6 invalid codes with carry 1 held
    for (int c = 4; c < 8; c++) drive(5'(c), 32'h1234_5678, 32'h1, 1, "R6");
    drive(5'd13, 32'hDEAD_BEEF, 32'h1, 1, "R6");
    drive(5'd31, 32'hDEAD_BEEF, 32'h1, 1, "R6");
    drive(5'd2, 32'd0, 32'd1, 1, "R3");                // carry -> 0
    drive(5'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R6");
    // R7: enable low holds carry though the adder would carry out
    drive(5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R7");
    drive(5'd1, 32'hFFFF_FFFF, 32'd1, 0, "R7");
    drive(5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R1");
    drive(5'd2, 32'd0, 32'd1, 0, "R7");
    // R9: result tracks carry in the same cycle it is visible
    drive(5'd1, 32'd0, 32'd0, 1, "R9");
    drive(5'd3, 32'd8, 32'd8, 0, "R9");

    @(negedge clk) en = 1'b0;
    while (q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule